// File: doc/BRIEF.md
# XOR Interleave Target Selector

This block maps a host physical address onto the index of the host-bridge target that serves it, under an interleave of 1, 2, 3, 4, 6, 8, 12 or 16 ways. For power-of-two interleaves, each index bit is the parity of the address after masking with a programmable 64-bit XOR map. For interleaves of 3, 6 and 12 ways, a base-3 digit is added. That digit is the remainder modulo 3 of the address with its bits below a lower bound cleared, and it is placed directly above the XOR-derived bits.

Software loads up to four XOR maps and a map count through a small write port. Each lookup request carries four things: the way count, the number of targets configured for the window, the granularity as a power-of-two exponent, and either a direct address or a window base plus a position number. In position mode the block first forms the address of the n'th granularity-sized chunk. The result appears one clock after the request strobe. It is either a 4-bit target index or an error flag. The flag is raised when the way count is unsupported or disagrees with the target count.

Top module: `xilv_target_sel`

## Requirements
- R1: With a way count of 1 (and a target count of 1) the index is 0 and the error flag is low, whatever the address and maps.
- R2: For 2, 4, 8 and 16 ways, index bit i (i below the map count) is the XOR reduction of the zero-extended 64-bit address ANDed with map i. Index bits at or above the map count are 0.
- R3: For 3 ways the XOR maps are not used. The index is (A & M) mod 3, where M clears address bits below the granularity exponent g and keeps bits up to 51.
- R4: For 6 ways (k=1) and 12 ways (k=2) the index is the XOR bits of R2 ORed with the value (A & M) mod 3 shifted left by the map count. Here M clears address bits below g+k. The result is truncated to 4 bits.
- R5: In position mode the address is (base + position * 2^g) modulo 2^52. In direct mode the address input is used as given.
- R6: When the way count differs from the target count, the error flag is set and the index is 0.
- R7: A way count outside {1,2,3,4,6,8,12,16} sets the error flag and gives index 0.
- R8: The index and the error flag are registered. The response strobe follows the request strobe by exactly one clock. Without a request, the index and flag keep their last values.
- R9: Write address 0 to 3 loads XOR map 0 to 3. Write address 4 loads the map count from the low data bits, saturated to 4. Writes to addresses 5 to 7 change nothing.
- R10: After reset the response strobe, index and error flag are 0, and all maps and the map count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_pos_mode | input | 1 | 1: address is base plus position times granularity |
| req_addr | input | 52 | Direct address, or window base in position mode |
| req_pos | input | 16 | Position number for position mode |
| req_ways | input | 5 | Interleave way count |
| req_targets | input | 5 | Number of targets configured for the window |
| req_gran | input | 4 | Granularity exponent (granularity = 2^req_gran bytes) |
| rsp_valid | output | 1 | Response strobe, one clock after req_valid |
| rsp_idx | output | 4 | Selected target index |
| rsp_err | output | 1 | Configuration error flag |

## Verification
The hardest case to reach from the ports is the 6- and 12-way index. Here the mod-3 digit lands at a bit position set by the map count, and it may be truncated when that count is high. The mask boundary also moves with both the granularity and the way count. The stimulus rewrites the map count and the maps at random between bursts of requests, and draws granularities across the full range. Directed requests place set address bits exactly at and just below the mask lower bound, and a position-mode case forces the 52-bit sum to wrap.

// File: rtl/xilv_pkg.sv
package xilv_pkg;

   localparam int WAYS_W = 5;

   typedef struct packed {
      logic       ok;       // supported way count
      logic       use_map;  // XOR-derived bits take part
      logic       use_mod;  // a base-3 digit takes part
      logic [1:0] k;        // log2(ways/3) for the 3*2^k family
   } ways_dec_t;

   function automatic ways_dec_t decode_ways(input logic [WAYS_W-1:0] w);
      ways_dec_t d;
      d = '0;
      unique case (w)
         5'd1:                    d.ok = 1'b1;
         5'd2, 5'd4, 5'd8, 5'd16: begin d.ok = 1'b1; d.use_map = 1'b1; end
         5'd3:                    begin d.ok = 1'b1; d.use_mod = 1'b1; end
         5'd6:  begin d.ok = 1'b1; d.use_map = 1'b1; d.use_mod = 1'b1; d.k = 2'd1; end
         5'd12: begin d.ok = 1'b1; d.use_map = 1'b1; d.use_mod = 1'b1; d.k = 2'd2; end
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/xilv_map_regs.sv
module xilv_map_regs #(
   parameter int NMAPS = 4,
   parameter int MAP_W = 64,
   parameter int CFG_AW = 3,
   parameter int CNT_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [CFG_AW-1:0]           addr,
   input  logic [MAP_W-1:0]            wdata,
   output logic [NMAPS-1:0][MAP_W-1:0] maps,
   output logic [CNT_W-1:0]            cnt
);
   localparam int CNT_ADDR = NMAPS;

   initial begin
      assert (CNT_ADDR < (1 << CFG_AW)) else $error("address space too small");
      assert (NMAPS < (1 << CNT_W)) else $error("count width too small");
   end

   for (genvar i = 0; i < NMAPS; i++) begin : g_map
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         maps[i] <= '0;
         else if (we && addr == CFG_AW'(i))  maps[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (we && addr == CFG_AW'(CNT_ADDR))
         cnt <= (wdata > MAP_W'(NMAPS)) ? CNT_W'(NMAPS) : wdata[CNT_W-1:0];
   end
endmodule

// File: rtl/xilv_xor_bits.sv
module xilv_xor_bits #(
   parameter int NMAPS = 4,
   parameter int MAP_W = 64,
   parameter int ADDR_W = 52,
   parameter int CNT_W = 3
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NMAPS-1:0][MAP_W-1:0] maps,
   input  logic [CNT_W-1:0]            cnt,
   output logic [NMAPS-1:0]            bits
);
   initial assert (ADDR_W <= MAP_W) else $error("address wider than map");

   logic [MAP_W-1:0] addr_ext;
   assign addr_ext = MAP_W'(addr);

   for (genvar i = 0; i < NMAPS; i++) begin : g_par
      assign bits[i] = (CNT_W'(i) < cnt) & (^(addr_ext & maps[i]));
   end
endmodule

// File: rtl/xilv_mod3.sv
module xilv_mod3 #(
   parameter int W = 52
) (
   input  logic [W-1:0] val,
   output logic [1:0]   rem
);
   localparam int NCH = (W + 1) / 2;
   localparam int PADW = 2 * NCH;

   initial assert (3 * NCH < 256) else $error("value too wide for 8-bit chunk sum");

   logic [PADW-1:0] padded;
   logic [7:0]      s0;
   logic [7:0]      s1, s2, s3;

   assign padded = PADW'(val);

   // 4 = 1 (mod 3): every 2-bit chunk carries weight 1
   always_comb begin
      s0 = '0;
      for (int c = 0; c < NCH; c++) s0 = s0 + 8'(padded[2*c +: 2]);
      s1 = 8'(s0[1:0]) + 8'(s0[3:2]) + 8'(s0[5:4]) + 8'(s0[7:6]);
      s2 = 8'(s1[1:0]) + 8'(s1[3:2]) + 8'(s1[5:4]) + 8'(s1[7:6]);
      s3 = 8'(s2[1:0]) + 8'(s2[3:2]) + 8'(s2[5:4]) + 8'(s2[7:6]);
      rem = (s3[1:0] == 2'd3) ? 2'd0 : s3[1:0];
   end
endmodule

// File: rtl/xilv_target_sel.sv
module xilv_target_sel #(
   parameter int ADDR_W = 52,
   parameter int MAP_W = 64,
   parameter int NMAPS = 4,
   parameter int IDX_W = 4,
   parameter int POS_W = 16,
   parameter int GRAN_W = 4,
   parameter int CFG_AW = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [MAP_W-1:0]              cfg_wdata,
   input  logic                          req_valid,
   input  logic                          req_pos_mode,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [POS_W-1:0]              req_pos,
   input  logic [xilv_pkg::WAYS_W-1:0]   req_ways,
   input  logic [xilv_pkg::WAYS_W-1:0]   req_targets,
   input  logic [GRAN_W-1:0]             req_gran,
   output logic                          rsp_valid,
   output logic [IDX_W-1:0]              rsp_idx,
   output logic                          rsp_err
);
   import xilv_pkg::*;

   localparam int CNT_W = $clog2(NMAPS + 1);
   localparam int LB_W = GRAN_W + 2;
   localparam int SH_W = IDX_W + 2;

   initial begin
      assert (POS_W < ADDR_W) else $error("position wider than address");
      assert (NMAPS <= IDX_W) else $error("more maps than index bits");
      assert (ADDR_W <= MAP_W) else $error("address wider than map");
   end

   logic [NMAPS-1:0][MAP_W-1:0] maps;
   logic [CNT_W-1:0]            map_cnt;
   logic [ADDR_W-1:0]           eff_addr;
   ways_dec_t                   dec;
   logic [NMAPS-1:0]            xbits;
   logic [LB_W-1:0]             lb;
   logic [MAP_W-1:0]            mod_mask;
   logic [ADDR_W-1:0]           mod_val;
   logic [1:0]                  mod_rem;
   logic [SH_W-1:0]             idx_wide;
   logic [IDX_W-1:0]            idx_next;
   logic                        err_next;

   xilv_map_regs #(.NMAPS(NMAPS), .MAP_W(MAP_W), .CFG_AW(CFG_AW), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .maps(maps), .cnt(map_cnt)
   );

   // position mode: base + pos * 2^gran, wrapping at the address width
   assign eff_addr = req_pos_mode ? (req_addr + (ADDR_W'(req_pos) << req_gran)) : req_addr;
   assign dec = decode_ways(req_ways);

   xilv_xor_bits #(.NMAPS(NMAPS), .MAP_W(MAP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) xor_i (
      .addr(eff_addr), .maps(maps), .cnt(map_cnt), .bits(xbits)
   );

   // mask built at full map width so the shift count always fits
   assign lb       = LB_W'(req_gran) + LB_W'(dec.k);
   assign mod_mask = {MAP_W{1'b1}} << lb;
   assign mod_val  = eff_addr & mod_mask[ADDR_W-1:0];

   xilv_mod3 #(.W(ADDR_W)) mod_i (.val(mod_val), .rem(mod_rem));

   always_comb begin
      idx_wide = '0;
      if (dec.use_map) idx_wide = SH_W'(xbits);
      if (dec.use_mod) idx_wide = idx_wide | (SH_W'(mod_rem) << (dec.use_map ? map_cnt : CNT_W'(0)));
      err_next = !dec.ok || (req_ways != req_targets);
      idx_next = err_next ? '0 : idx_wide[IDX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_idx   <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_idx <= idx_next;
            rsp_err <= err_next;
         end
      end
   end
endmodule

// File: rtl/xilv_target_sel_chk.sv
module xilv_target_sel_chk #(
   parameter int IDX_W = 4,
   parameter int WAYS_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [WAYS_W-1:0] req_ways,
   input logic [WAYS_W-1:0] req_targets,
   input logic              rsp_valid,
   input logic [IDX_W-1:0]  rsp_idx,
   input logic              rsp_err
);
   a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_idx) && $stable(rsp_err)));

   a_r1_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ways == 1 && req_targets == 1) |=> (!rsp_err && rsp_idx == '0));

   a_r6_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ways != req_targets) |=> rsp_err);

   a_r6_err_no_index: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_idx == '0));

   a_r7_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_ways == 0 || req_ways == 5 || req_ways == 7 || req_ways == 9 ||
                     req_ways == 10 || req_ways > 16)) |=> rsp_err);

   a_r3_three_range: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ways == 3 && req_targets == 3) |=> (rsp_idx < 3));
endmodule

bind xilv_target_sel xilv_target_sel_chk #(.IDX_W(IDX_W), .WAYS_W(xilv_pkg::WAYS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ways(req_ways),
   .req_targets(req_targets), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_err(rsp_err)
);

// File: tb/xilv_target_sel_tb.sv
module xilv_target_sel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_pos_mode = 1'b0;
   logic [51:0] req_addr = '0;
   logic [15:0] req_pos = '0;
   logic [4:0]  req_ways = 5'd1;
   logic [4:0]  req_targets = 5'd1;
   logic [3:0]  req_gran = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_idx;
   logic        rsp_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [63:0] m_map [4];
   int          m_cnt;

   always #5 clk = ~clk;

   xilv_target_sel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_pos_mode(req_pos_mode), .req_addr(req_addr), .req_pos(req_pos),
      .req_ways(req_ways), .req_targets(req_targets), .req_gran(req_gran),
      .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_err(rsp_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [51:0] ref_addr(input logic [51:0] a, input logic [15:0] p,
                                            input logic [3:0] g, input bit pm);
      logic [63:0] s;
      s = {12'b0, a} + ({48'b0, p} * (64'd1 << g));
      return pm ? s[51:0] : a;
   endfunction

   // expected index from the requirement text
   function automatic logic [3:0] ref_idx(input logic [51:0] a, input logic [4:0] w,
                                          input logic [4:0] nt, input logic [3:0] g,
                                          output bit e);
      logic [63:0] a64, mv;
      logic [7:0]  r;
      int          k;
      bit          mp, md, ok;
      a64 = {12'b0, a};
      ok = 1; mp = 0; md = 0; k = 0;
      if (w == 1) begin end
      else if (w == 2 || w == 4 || w == 8 || w == 16) mp = 1;
      else if (w == 3) md = 1;
      else if (w == 6) begin mp = 1; md = 1; k = 1; end
      else if (w == 12) begin mp = 1; md = 1; k = 2; end
      else ok = 0;
      e = !ok || (w != nt);
      if (e) return 4'd0;
      r = 0;
      if (mp) for (int i = 0; i < m_cnt; i++) r[i] = ^(a64 & m_map[i]);
      if (md) begin
         mv = a64 & (~64'd0 << (g + k));
         r = r | (8'(mv % 3) << (mp ? m_cnt : 0));
      end
      return r[3:0];
   endfunction

   task automatic wr(input logic [2:0] ad, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = ad; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      if (ad < 4) m_map[ad] = d;
      else if (ad == 4) m_cnt = (d > 4) ? 4 : int'(d[2:0]);
   endtask

   task automatic lookup(input string req, input logic [51:0] a, input logic [15:0] p, input bit pm,
                         input logic [4:0] w, input logic [4:0] nt, input logic [3:0] g);
      logic [3:0] ei;
      bit         ee;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_pos = p; req_pos_mode = pm;
      req_ways = w; req_targets = nt; req_gran = g;
      ei = ref_idx(ref_addr(a, p, g, pm), w, nt, g, ee);
      @(negedge clk);
      req_valid = 0;
      check({req, " valid"}, 64'(rsp_valid), 64'd1);
      check({req, " idx"}, 64'(rsp_idx), 64'(ei));
      check({req, " err"}, 64'(rsp_err), 64'(ee));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      logic [4:0] wl [8];
      logic [4:0] w, nt;
      logic [3:0] pi, pe;
      seed = 17;
      void'($urandom(seed));
      wl = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16};
      for (int i = 0; i < 4; i++) m_map[i] = '0;
      m_cnt = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 rsp_valid", 64'(rsp_valid), 0);
      check("R10 rsp_idx", 64'(rsp_idx), 0);
      check("R10 rsp_err", 64'(rsp_err), 0);
      rst_n = 1;
      // R10: maps and count zero after reset -> 16-way idx 0
      lookup("R10 maps cleared", 52'hF_FFFF_FFFF_FFFF, 0, 0, 16, 16, 0);

      wr(0, 64'h0000_0000_0000_0100);
      wr(1, 64'h0000_0000_0000_0200);
      wr(2, 64'h0000_0000_0000_0400);
      wr(3, 64'h0000_0000_0000_0800);
      wr(4, 64'd4);
      // R2: single-bit maps select address bits 8..11
      lookup("R2 bit select", 52'h0000_0000_0A00, 0, 0, 16, 16, 8);
      check("R2 direct value", 64'(rsp_idx), 64'hA);
      // R1
      lookup("R1 one way", 52'h0000_0000_0F00, 0, 0, 1, 1, 8);
      // R3: maps ignored, 0x300 masked at g=8 -> 768 mod 3 = 0; 0x100 -> 256 mod 3 = 1
      lookup("R3 three way a", 52'h0000_0000_0100, 0, 0, 3, 3, 8);
      check("R3 direct value", 64'(rsp_idx), 64'd1);
      lookup("R3 below bound", 52'h0000_0000_00FF, 0, 0, 3, 3, 8);
      check("R3 below bound zero", 64'(rsp_idx), 64'd0);
      // R4: 12 ways with count 2
      wr(4, 64'd2);
      lookup("R4 twelve way", 52'h0000_0000_0500, 0, 0, 12, 12, 8);
      lookup("R4 six way edge", 52'h0000_0000_0100, 0, 0, 6, 6, 8);
      check("R4 bit below g+k dropped", 64'(rsp_idx), 64'h1);
      // R4: truncation with count 4
      wr(4, 64'd4);
      lookup("R4 truncated digit", 52'h0000_0000_1000, 0, 0, 6, 6, 8);
      // R9: saturation and ignored addresses
      wr(4, 64'd7);
      wr(5, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(7, 64'hFFFF_FFFF_FFFF_FFFF);
      lookup("R9 ignored writes", 52'h0000_0000_0300, 0, 0, 8, 8, 8);
      check("R9 map count saturated", 64'(rsp_idx), 64'h3);
      // R6, R7
      lookup("R6 way mismatch", 52'h123, 0, 0, 4, 8, 8);
      lookup("R7 five ways", 52'h123, 0, 0, 5, 5, 8);
      lookup("R7 ten ways", 52'h123, 0, 0, 10, 10, 8);
      // R5: position mode with wrap
      lookup("R5 position wrap", 52'hF_FFFF_FFFF_FF00, 16'h0003, 1, 16, 16, 8);
      lookup("R5 position plain", 52'h0, 16'h0005, 1, 3, 3, 8);
      check("R5 pos 5 g8 mod3", 64'(rsp_idx), 64'd2);
      // R8: hold without request
      pi = rsp_idx; pe = 4'(rsp_err);
      @(negedge clk);
      req_addr = 52'hABCDE; req_ways = 5'd16; req_targets = 5'd16;
      @(negedge clk);
      check("R8 no strobe", 64'(rsp_valid), 0);
      check("R8 idx held", 64'(rsp_idx), 64'(pi));
      check("R8 err held", 64'(rsp_err), 64'(pe));

      // random mix over R1-style cases through all families
      for (int it = 0; it < 400; it++) begin
         if (it % 40 == 0) begin
            for (int m = 0; m < 4; m++) wr(3'(m), {$urandom, $urandom});
            wr(4, 64'($urandom_range(0, 5)));
         end
         w = wl[$urandom_range(0, 7)];
         if ($urandom_range(0, 9) == 0) w = 5'($urandom_range(0, 31));
         nt = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(1, 16)) : w;
         lookup("R2 R3 R4 R5 R6 random", {$urandom, $urandom}, 16'($urandom),
                bit'($urandom_range(0, 1)), w, nt, 4'($urandom));
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule